// File: doc/BRIEF.md
# Register File with Compare Unit

This block holds the working registers of a small 24-bit accumulator machine and executes register-form instructions against them. Each instruction names an operation and two 4-bit register numbers, r1 and r2. The block reads both registers combinationally. It computes a move, a wrapping add or subtract, the low word of a product, a signed compare, or a fused step that increments the index register and compares it. Results and the three-state condition code are written on the next clock edge.

A separate load port lets the surrounding pipeline place a word into any storage register, for example after a memory read. A combinational read port returns any register by number. The status word returns the condition code in its two lowest bits. A jump-select input is checked against the current condition code, so a branch unit can see at once whether a conditional jump is taken. An instruction that names a register number with no storage behind it raises a flag and changes nothing.

Top module: `rcu_top`

## Requirements
- R1: After reset every storage register reads zero and the condition code reads 01 (equal).
- R2: Storage registers are numbered accumulator 0, index 1, link 2, base 3, S 4, T 5 and program counter 8. The load port writes any of these on a clock edge. Reads through rdIdx are combinational. Numbers 6, 7 and 10 to 15 read zero, and load-port writes to them or to 9 have no effect.
- R3: Operation code 0 (move) copies register r1 into register r2.
- R4: Operation code 1 writes r2 + r1 into r2, and operation code 2 writes r2 - r1 into r2. Both wrap modulo 2^24.
- R5: Operation code 3 writes the low 24 bits of r2 * r1 into r2.
- R6: Operation code 4 compares r1 with r2 as signed 24-bit values and sets the condition code to 00 when r1 < r2, 01 when they are equal and 10 when r1 > r2. Codes 0 to 3 leave the condition code unchanged.
- R7: Operation code 5 writes X + 1 (wrapping) into the index register. It sets the condition code by comparing that new X, signed, with register r1, so r1 = 1 gives equal. Field r2 is ignored.
- R8: Register number 9 reads as 22 zero bits followed by the condition code. Naming 9 as the destination of codes 0 to 3 is illegal.
- R9: An instruction with opValid high and code 0 to 5 raises illegalReg combinationally in the same cycle if any register it uses is 6, 7 or 10 to 15, or if it writes 9. Such an instruction changes no register and leaves the condition code unchanged. Codes 6 and 7 change nothing and raise no flag.
- R10: jumpTaken is combinational. jmpSel 00 never takes the jump, and 01, 10 and 11 take it when the condition code is less, equal or greater respectively.
- R11: When the load port and an instruction write the same register in one cycle, the instruction's result is kept. Writes to different registers both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Instruction present this cycle |
| opSel | input | 3 | Operation code |
| r1 | input | 4 | First register number |
| r2 | input | 4 | Second register number |
| loadEn | input | 1 | Load port write enable |
| loadIdx | input | 4 | Load port register number |
| loadData | input | 24 | Load port data |
| rdIdx | input | 4 | Read port register number |
| rdData | output | 24 | Read port data |
| jmpSel | input | 2 | Jump condition select |
| jumpTaken | output | 1 | Selected jump condition holds |
| ccOut | output | 2 | Current condition code |
| illegalReg | output | 1 | Instruction names an unusable register |

## Verification
The bench builds the block with its default 24-bit data width and 4-bit register numbers. At these values the wrap at 2^24, the sign boundary at 0x800000 and every one of the sixteen register numbers can be reached with directed values. Each scenario is compared against a model written from the requirements. After each step, all sixteen numbers are swept through the read port, so any stray write becomes visible.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

  localparam int DATA_W_DEF = 24;
  localparam int RNUM_W_DEF = 4;

  localparam int REG_A  = 0;
  localparam int REG_X  = 1;
  localparam int REG_PC = 8;
  localparam int REG_SW = 9;

  typedef enum logic [2:0] {
    OP_MOVE   = 3'd0,
    OP_ADD    = 3'd1,
    OP_SUB    = 3'd2,
    OP_MUL    = 3'd3,
    OP_CMP    = 3'd4,
    OP_INCCMP = 3'd5
  } opKind_t;

  typedef enum logic [1:0] {
    CC_LT = 2'b00,
    CC_EQ = 2'b01,
    CC_GT = 2'b10
  } cc_t;

  typedef struct packed {
    logic    wrDst;
    logic    wrIdx;
    logic    ccUpd;
    opKind_t fn;
  } strobe_t;

  function automatic logic isStorage(input int n);
    return (n >= 0 && n <= 5) || n == REG_PC;
  endfunction

  function automatic logic isReadable(input int n);
    return isStorage(n) || n == REG_SW;
  endfunction

endpackage

// File: rtl/rcu_ctrl.sv
module rcu_ctrl
  import rcu_pkg::*;
#(
  parameter int RNUM_W = RNUM_W_DEF
) (
  input  logic              opValid,
  input  logic [2:0]        opSel,
  input  logic [RNUM_W-1:0] r1,
  input  logic [RNUM_W-1:0] r2,
  input  logic [1:0]        jmpSel,
  input  logic [1:0]        ccCur,
  output strobe_t           strb,
  output logic              illegalReg,
  output logic              jumpTaken
);

  opKind_t kind;
  logic    knownOp;
  logic    usesR2;
  logic    writesR2;
  logic    badReg;
  logic    go;

  always_comb begin
    kind     = opKind_t'(opSel);
    knownOp  = (opSel <= 3'd5);
    usesR2   = (kind != OP_INCCMP);
    writesR2 = (kind == OP_MOVE) || (kind == OP_ADD) ||
               (kind == OP_SUB)  || (kind == OP_MUL);
    badReg   = !isReadable(int'(r1)) ||
               (usesR2 && !isReadable(int'(r2))) ||
               (writesR2 && !isStorage(int'(r2)));
    go         = opValid && knownOp && !badReg;
    illegalReg = opValid && knownOp && badReg;
  end

  always_comb begin
    strb.wrDst = go && writesR2;
    strb.wrIdx = go && (kind == OP_INCCMP);
    strb.ccUpd = go && ((kind == OP_CMP) || (kind == OP_INCCMP));
    strb.fn    = kind;
  end

  always_comb begin
    unique case (jmpSel)
      2'b01:   jumpTaken = (ccCur == CC_LT);
      2'b10:   jumpTaken = (ccCur == CC_EQ);
      2'b11:   jumpTaken = (ccCur == CC_GT);
      default: jumpTaken = 1'b0;
    endcase
  end

endmodule

// File: rtl/rcu_datapath.sv
module rcu_datapath
  import rcu_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int RNUM_W = RNUM_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [RNUM_W-1:0] r1,
  input  logic [RNUM_W-1:0] r2,
  input  logic              loadEn,
  input  logic [RNUM_W-1:0] loadIdx,
  input  logic [DATA_W-1:0] loadData,
  input  logic [RNUM_W-1:0] rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        ccOut
);

  localparam int NUM_SLOTS = 1 << RNUM_W;
  localparam int PROD_W    = 2 * DATA_W;
  localparam logic [RNUM_W-1:0] X_NUM = RNUM_W'(REG_X);

  logic [DATA_W-1:0] view [NUM_SLOTS];
  logic [DATA_W-1:0] r1Val, r2Val, xVal, xNext;
  logic [DATA_W-1:0] aluRes;
  logic [PROD_W-1:0] prod;
  logic [DATA_W-1:0] cmpL, cmpR;
  cc_t               ccNext;
  cc_t               ccQ;

  assign r1Val = view[r1];
  assign r2Val = view[r2];
  assign xVal  = view[REG_X];
  assign xNext = xVal + DATA_W'(1);

  always_comb begin
    prod = {{DATA_W{1'b0}}, r2Val} * {{DATA_W{1'b0}}, r1Val};
    unique case (strb.fn)
      OP_ADD:  aluRes = r2Val + r1Val;
      OP_SUB:  aluRes = r2Val - r1Val;
      OP_MUL:  aluRes = prod[DATA_W-1:0];
      default: aluRes = r1Val;
    endcase
  end

  always_comb begin
    if (strb.fn == OP_INCCMP) begin
      cmpL = xNext;
      cmpR = (r1 == X_NUM) ? xNext : r1Val;
    end else begin
      cmpL = r1Val;
      cmpR = r2Val;
    end
    if ($signed(cmpL) < $signed(cmpR))
      ccNext = CC_LT;
    else if (cmpL == cmpR)
      ccNext = CC_EQ;
    else
      ccNext = CC_GT;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : g_slot
      localparam logic [RNUM_W-1:0] SLOT = RNUM_W'(g);
      if (isStorage(g)) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            q <= '0;
          else if (strb.wrDst && r2 == SLOT)
            q <= aluRes;
          else if (strb.wrIdx && SLOT == X_NUM)
            q <= xNext;
          else if (loadEn && loadIdx == SLOT)
            q <= loadData;
        end
        assign view[g] = q;
      end else if (g == REG_SW) begin : g_sw
        assign view[g] = {{(DATA_W-2){1'b0}}, ccQ};
      end else begin : g_none
        assign view[g] = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ccQ <= CC_EQ;
    else if (strb.ccUpd)
      ccQ <= ccNext;
  end

  assign rdData = view[rdIdx];
  assign ccOut  = ccQ;

endmodule

// File: rtl/rcu_top.sv
module rcu_top
  import rcu_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int RNUM_W = RNUM_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [2:0]        opSel,
  input  logic [RNUM_W-1:0] r1,
  input  logic [RNUM_W-1:0] r2,
  input  logic              loadEn,
  input  logic [RNUM_W-1:0] loadIdx,
  input  logic [DATA_W-1:0] loadData,
  input  logic [RNUM_W-1:0] rdIdx,
  output logic [DATA_W-1:0] rdData,
  input  logic [1:0]        jmpSel,
  output logic              jumpTaken,
  output logic [1:0]        ccOut,
  output logic              illegalReg
);

  strobe_t strb;

  rcu_ctrl #(.RNUM_W(RNUM_W)) u_ctrl (
    .opValid   (opValid),
    .opSel     (opSel),
    .r1        (r1),
    .r2        (r2),
    .jmpSel    (jmpSel),
    .ccCur     (ccOut),
    .strb      (strb),
    .illegalReg(illegalReg),
    .jumpTaken (jumpTaken)
  );

  rcu_datapath #(.DATA_W(DATA_W), .RNUM_W(RNUM_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .r1      (r1),
    .r2      (r2),
    .loadEn  (loadEn),
    .loadIdx (loadIdx),
    .loadData(loadData),
    .rdIdx   (rdIdx),
    .rdData  (rdData),
    .ccOut   (ccOut)
  );

endmodule

// File: rtl/rcu_checker.sv
module rcu_checker
  import rcu_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int RNUM_W = RNUM_W_DEF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              opValid,
  input logic [2:0]        opSel,
  input logic [RNUM_W-1:0] rdIdx,
  input logic [DATA_W-1:0] rdData,
  input logic [1:0]        jmpSel,
  input logic              jumpTaken,
  input logic [1:0]        ccOut,
  input logic              illegalReg
);

  // R6: the condition code only ever holds one of its three encodings
  a_r6_cc_encoding: assert property (@(posedge clk) disable iff (!rst_n)
    ccOut != 2'b11);

  // R6: move and arithmetic leave the condition code alone
  a_r6_arith_keeps_cc: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && !illegalReg && opSel <= 3'd3) |=> $stable(ccOut));

  // R9: a rejected instruction leaves the condition code alone
  a_r9_illegal_keeps_cc: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && illegalReg) |=> $stable(ccOut));

  // R8: the status word reads back the condition code
  a_r8_sw_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rdIdx == RNUM_W'(REG_SW)) |-> (rdData == {{(DATA_W-2){1'b0}}, ccOut}));

  // R2: numbers without storage read zero
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !isReadable(int'(rdIdx)) |-> (rdData == '0));

  // R10: select 00 never takes the jump
  a_r10_never_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (jmpSel == 2'b00) |-> !jumpTaken);

endmodule

bind rcu_top rcu_checker #(.DATA_W(DATA_W), .RNUM_W(RNUM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .opValid   (opValid),
  .opSel     (opSel),
  .rdIdx     (rdIdx),
  .rdData    (rdData),
  .jmpSel    (jmpSel),
  .jumpTaken (jumpTaken),
  .ccOut     (ccOut),
  .illegalReg(illegalReg)
);

// File: tb/rcu_top_bench.sv
module rcu_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [3:0]  r1 = 4'd0;
  logic [3:0]  r2 = 4'd0;
  logic        loadEn = 1'b0;
  logic [3:0]  loadIdx = 4'd0;
  logic [23:0] loadData = 24'd0;
  logic [3:0]  rdIdx = 4'd0;
  logic [23:0] rdData;
  logic [1:0]  jmpSel = 2'b00;
  logic        jumpTaken;
  logic [1:0]  ccOut;
  logic        illegalReg;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [23:0] mdl [16];
  logic [1:0]  mcc;

  always #4 clk = ~clk;

  rcu_top u_rcu_top (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opSel(opSel),
    .r1(r1), .r2(r2), .loadEn(loadEn), .loadIdx(loadIdx),
    .loadData(loadData), .rdIdx(rdIdx), .rdData(rdData),
    .jmpSel(jmpSel), .jumpTaken(jumpTaken), .ccOut(ccOut),
    .illegalReg(illegalReg)
  );

  function automatic bit hasStore(input int n);
    return (n <= 5) || n == 8;
  endfunction

  function automatic bit canRead(input int n);
    return hasStore(n) || n == 9;
  endfunction

  function automatic logic [1:0] ccOf(input logic [23:0] a, input logic [23:0] b);
    if ($signed(a) < $signed(b)) return 2'b00;
    if (a == b) return 2'b01;
    return 2'b10;
  endfunction

  function automatic logic [23:0] mdlRead(input int n);
    if (n == 9) return {22'd0, mcc};
    if (hasStore(n)) return mdl[n];
    return 24'd0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [23:0] act,
                       input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic verifyAll(input string req);
    for (int n = 0; n < 16; n++) begin
      rdIdx = 4'(n);
      #1;
      check(rdData === mdlRead(n), req, rdData, mdlRead(n));
    end
    check(ccOut === mcc, req, {22'd0, ccOut}, {22'd0, mcc});
  endtask

  task automatic loadReg(input int n, input logic [23:0] v);
    @(negedge clk);
    loadEn = 1'b1; loadIdx = 4'(n); loadData = v;
    @(posedge clk);
    @(negedge clk);
    loadEn = 1'b0;
    if (hasStore(n)) mdl[n] = v;
  endtask

  // applies an instruction to the bench model and returns whether it is illegal
  function automatic bit mdlOp(input int sel, input int a, input int b,
                               input bit skipWrite);
    bit bad;
    logic [23:0] va, vb, nx;
    if (sel > 5) return 1'b0;
    bad = !canRead(a) || (sel != 5 && !canRead(b)) || (sel <= 3 && !hasStore(b));
    if (bad) return 1'b1;
    va = mdlRead(a);
    vb = mdlRead(b);
    case (sel)
      0: mdl[b] = va;
      1: mdl[b] = vb + va;
      2: mdl[b] = vb - va;
      3: mdl[b] = vb * va;
      4: mcc = ccOf(va, vb);
      default: begin
        nx = mdl[1] + 24'd1;
        mcc = ccOf(nx, (a == 1) ? nx : va);
        mdl[1] = nx;
      end
    endcase
    return 1'b0;
  endfunction

  task automatic runOp(input int sel, input int a, input int b, input string req);
    bit expBad;
    @(negedge clk);
    opValid = 1'b1; opSel = 3'(sel); r1 = 4'(a); r2 = 4'(b);
    #1;
    expBad = mdlOp(sel, a, b, 1'b0);
    check(illegalReg === expBad, req, {23'd0, illegalReg}, {23'd0, expBad});
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic t_reset;
    for (int n = 0; n < 16; n++) mdl[n] = 24'd0;
    mcc = 2'b01;
    verifyAll("R1");
  endtask

  task automatic t_load;
    for (int n = 0; n < 16; n++) loadReg(n, 24'h100000 + 24'(n * 4369));
    verifyAll("R2");
  endtask

  task automatic t_move;
    runOp(0, 0, 5, "R3");
    runOp(0, 4, 8, "R3");
    runOp(0, 9, 2, "R3 R8");
    verifyAll("R3");
  endtask

  task automatic t_addsub;
    loadReg(0, 24'hFFFFFF); loadReg(3, 24'd1);
    runOp(1, 3, 0, "R4");
    verifyAll("R4 add wrap");
    runOp(2, 3, 0, "R4");
    verifyAll("R4 sub wrap");
    loadReg(4, 24'd1000); loadReg(5, 24'd58);
    runOp(2, 5, 4, "R4");
    runOp(1, 4, 5, "R4");
    verifyAll("R4");
  endtask

  task automatic t_mul;
    loadReg(0, 24'h001000); loadReg(2, 24'h001000);
    runOp(3, 0, 2, "R5");
    verifyAll("R5 overflow");
    loadReg(4, 24'hFFFFFF); loadReg(5, 24'd3);
    runOp(3, 4, 5, "R5");
    loadReg(3, 24'd1234); loadReg(8, 24'd56);
    runOp(3, 3, 8, "R5");
    verifyAll("R5");
  endtask

  task automatic t_cmp;
    loadReg(0, 24'h800000); loadReg(1, 24'd1);
    runOp(4, 0, 1, "R6");
    verifyAll("R6 less signed");
    loadReg(2, 24'd5); loadReg(3, 24'd5);
    runOp(4, 2, 3, "R6");
    verifyAll("R6 equal");
    loadReg(4, 24'd1); loadReg(5, 24'hFFFFFF);
    runOp(4, 4, 5, "R6");
    verifyAll("R6 greater");
    runOp(1, 4, 5, "R6");
    verifyAll("R6 add keeps cc");
  endtask

  task automatic t_inccmp;
    loadReg(1, 24'd9); loadReg(5, 24'd11);
    runOp(5, 5, 12, "R7");
    verifyAll("R7 less");
    runOp(5, 5, 0, "R7");
    verifyAll("R7 equal");
    runOp(5, 5, 0, "R7");
    verifyAll("R7 greater");
    runOp(5, 1, 7, "R7");
    verifyAll("R7 self compare");
    loadReg(1, 24'hFFFFFF); loadReg(0, 24'd0);
    runOp(5, 0, 3, "R7");
    verifyAll("R7 wrap");
  endtask

  task automatic t_illegal;
    loadReg(0, 24'd77); loadReg(2, 24'd3);
    runOp(1, 6, 0, "R9");
    runOp(0, 0, 7, "R9");
    runOp(4, 0, 12, "R9");
    runOp(5, 15, 0, "R9");
    runOp(1, 0, 9, "R8 R9");
    verifyAll("R9 no change");
    runOp(6, 0, 2, "R9");
    runOp(7, 2, 0, "R9");
    verifyAll("R9 unused codes");
  endtask

  task automatic t_jump;
    loadReg(4, 24'd2); loadReg(5, 24'd8);
    for (int k = 0; k < 3; k++) begin
      case (k)
        0: runOp(4, 4, 5, "R10");
        1: runOp(4, 4, 4, "R10");
        default: runOp(4, 5, 4, "R10");
      endcase
      for (int j = 0; j < 4; j++) begin
        bit exp;
        jmpSel = 2'(j);
        #1;
        exp = (j == 1 && mcc == 2'b00) || (j == 2 && mcc == 2'b01) ||
              (j == 3 && mcc == 2'b10);
        check(jumpTaken === exp, "R10", {23'd0, jumpTaken}, {23'd0, exp});
      end
      jmpSel = 2'b00;
    end
  endtask

  task automatic t_collide;
    loadReg(3, 24'd40); loadReg(4, 24'd2);
    @(negedge clk);
    opValid = 1'b1; opSel = 3'd1; r1 = 4'd4; r2 = 4'd3;
    loadEn = 1'b1; loadIdx = 4'd3; loadData = 24'hABCDEF;
    void'(mdlOp(1, 4, 3, 1'b0));
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0; loadEn = 1'b0;
    verifyAll("R11 op wins");
    @(negedge clk);
    opValid = 1'b1; opSel = 3'd0; r1 = 4'd4; r2 = 4'd5;
    loadEn = 1'b1; loadIdx = 4'd8; loadData = 24'h123456;
    void'(mdlOp(0, 4, 5, 1'b0));
    mdl[8] = 24'h123456;
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0; loadEn = 1'b0;
    verifyAll("R11 both");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_move();
    t_addsub();
    t_mul();
    t_cmp();
    t_inccmp();
    t_illegal();
    t_jump();
    t_collide();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule